// File: doc/BRIEF.md
# Address Monitor Wait Unit

This unit holds the wake-up logic for a core that parks itself until memory it cares about changes. A monitor command arms a watch on the 64-byte line that holds one address. A following wait command puts the core into a low-power wait state. The wait command carries a hint byte that names the target C-state and sub-state, plus a 32-bit extension word. The unit snoops a store bus for writes to the armed line. It also watches an interrupt input and, in the timed variant, a per-wait countdown measured in reference clocks. It ends the wait with a one-cycle wake pulse and a cause code.

Illegal operand bits give a one-cycle fault pulse, and the command then has no effect. A wait that cannot sleep finishes at once with its own cause code. This happens when nothing is armed, or when the armed line was already written after arming. The C-state and sub-state outputs carry the hint fields for as long as the core waits.

Top module: `monitor_wait_unit`

## Requirements
- R1: A monitor command with an all-zero extension word arms the line `mon_addr >> 6` and clears any earlier write record. A nonzero extension word gives a fault pulse one cycle later and leaves the armed state as it was.
- R2: A wait command faults, and does not wait or wake, if any of extension bits 31:2 is set, or if bit 1 is set while `wait_timed` is 0. The armed state is kept.
- R3: A legal wait issued while nothing is armed, or after a store hit the armed line (this includes a hit in the same cycle), does not enter the wait state. It gives a wake pulse with cause 3 one cycle later.
- R4: While waiting, a snooped store to any byte of the armed 64-byte line ends the wait, with wake cause 0 in the next cycle. Stores to other lines have no effect.
- R5: When `wait_timed`=1 and extension bit 1 is set, a limit L loads a countdown. The wait then lasts L+1 cycles and ends with cause 1, so L=0 ends one cycle after entry. When the timer is not enabled, the wait never times out.
- R6: While waiting, `irq_pending` ends the wait with cause 2 if `irq_enabled` is 1 or extension bit 0 was set. A masked interrupt without bit 0 has no effect.
- R7: If several wake conditions hold in the same cycle, the cause picks store (0) first, then interrupt (2), then timer (1).
- R8: `wake_pulse` lasts one cycle. `waiting` falls on the same edge that raises it. Every wake, immediate wakes included, disarms the monitor.
- R9: While waiting, `cstate` = hint[7:4] and `substate` = hint[3:0]. Both read 0 when not waiting. `deep_disabled` is high while waiting with `cstate`=0xF.
- R10: Monitor and wait commands are ignored while waiting. A monitor command in the same cycle as a wait command is ignored.
- R11: After reset, `waiting`, `wake_pulse`, `fault`, `cstate`, `substate` and `deep_disabled` are 0 and nothing is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Monitor command strobe |
| mon_addr | input | ADDR_W | Address to watch |
| mon_ext | input | 32 | Monitor extension word, must be zero |
| wait_valid | input | 1 | Wait command strobe |
| wait_timed | input | 1 | 1 selects the timed wait variant |
| wait_hint | input | 8 | C-state in [7:4], sub-state in [3:0] |
| wait_ext | input | 32 | Bit 0 interrupt break, bit 1 timer enable, rest reserved |
| wait_limit | input | CNT_W | Maximum wait length in reference clocks |
| snoop_valid | input | 1 | Snooped store strobe |
| snoop_addr | input | ADDR_W | Snooped store address |
| irq_pending | input | 1 | An interrupt is pending |
| irq_enabled | input | 1 | Interrupts are unmasked |
| waiting | output | 1 | Core is in the wait state |
| wake_pulse | output | 1 | One-cycle wake strobe |
| wake_cause | output | 2 | 0 store, 1 timer, 2 interrupt, 3 no wait entered |
| fault | output | 1 | One-cycle illegal-operand strobe |
| cstate | output | 4 | Target C-state while waiting |
| substate | output | 4 | Target sub-state while waiting |
| deep_disabled | output | 1 | Waiting with deeper C-states disabled |

## Verification
On every cycle the assertions check several invariants. The wake pulse never overlaps the wait state, and the monitor is disarmed whenever the wake strobe is high. Store hits win over interrupts, and interrupts win over timer expiry. The countdown falls by exactly one per cycle, commands are shut out while waiting, and the C-state output stays fixed for the whole wait. Some behaviours only the bench's scenarios can show. These are the exact length of a timed wait for a given limit, and that a write record taken before the wait turns it into an immediate completion. They also include that faulted commands leave the armed line usable, and that a monitor command issued during a wait has no later effect.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam int EXT_W = 32;
  localparam logic [3:0] CST_NO_DEEP = 4'hF;

  typedef enum logic [1:0] {
    CAUSE_STORE  = 2'd0,
    CAUSE_TIMER  = 2'd1,
    CAUSE_IRQ    = 2'd2,
    CAUSE_NOWAIT = 2'd3
  } wake_cause_e;

  function automatic logic mon_ext_bad(input logic [EXT_W-1:0] ext);
    return |ext;
  endfunction

  function automatic logic wait_ext_bad(input logic [EXT_W-1:0] ext, input logic timed);
    return (|ext[EXT_W-1:2]) || (!timed && ext[1]);
  endfunction

  function automatic wake_cause_e wake_pick(input logic hit, input logic irq);
    if (hit)      return CAUSE_STORE;
    else if (irq) return CAUSE_IRQ;
    else          return CAUSE_TIMER;
  endfunction
endpackage

// File: rtl/awu_line_watch.sv
module awu_line_watch #(
  parameter int ADDR_W    = 48,
  parameter int LINE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_set,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              disarm,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              armed,
  output logic              dirty,
  output logic              hit
);
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] snoop_line;

  assign snoop_line = snoop_addr >> LINE_BITS;
  assign hit        = snoop_valid && armed && (snoop_line == line_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      dirty  <= 1'b0;
      line_q <= '0;
    end else if (arm_set) begin
      armed  <= 1'b1;
      dirty  <= 1'b0;
      line_q <= arm_addr >> LINE_BITS;
    end else if (disarm) begin
      armed <= 1'b0;
      dirty <= 1'b0;
    end else if (hit) begin
      dirty <= 1'b1;
    end
  end

  // R3: a write record exists only for an armed line
  p_dirty_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> armed);
  // R1: arming starts with a clean record
  p_arm_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> armed && !dirty);
endmodule

// File: rtl/awu_countdown.sv
module awu_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop,
  output logic             expired
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  assign expired = en_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      en_q  <= load_en;
      cnt_q <= load_val;
    end else if (stop) begin
      en_q <= 1'b0;
    end else if (en_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: one step down per cycle while running
  p_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && (cnt_q != '0) && !load && !stop |=> cnt_q == $past(cnt_q) - 1'b1);
  // R5: once expired, stays expired until reloaded or stopped
  p_expire_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load && !stop |=> expired);
endmodule

// File: rtl/awu_wake_arb.sv
module awu_wake_arb
  import awu_pkg::*;
(
  input  logic        store_hit,
  input  logic        irq_ok,
  input  logic        tmo,
  output logic        any,
  output wake_cause_e cause
);
  assign any   = store_hit || irq_ok || tmo;
  assign cause = wake_pick(store_hit, irq_ok);
endmodule

// File: rtl/monitor_wait_unit.sv
module monitor_wait_unit
  import awu_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LINE_BITS = 6,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [EXT_W-1:0]  mon_ext,
  input  logic              wait_valid,
  input  logic              wait_timed,
  input  logic [7:0]        wait_hint,
  input  logic [EXT_W-1:0]  wait_ext,
  input  logic [CNT_W-1:0]  wait_limit,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              irq_pending,
  input  logic              irq_enabled,
  output logic              waiting,
  output logic              wake_pulse,
  output logic [1:0]        wake_cause,
  output logic              fault,
  output logic [3:0]        cstate,
  output logic [3:0]        substate,
  output logic              deep_disabled
);
  // named internal events
  logic        armed, dirty, store_hit;
  logic        timer_expired, irq_ok, wake_any, wake_now;
  logic        wait_go, wait_bad, wait_imm, wait_enter;
  logic        mon_go, mon_bad, arm_set, disarm;
  logic        brk_q;
  wake_cause_e arb_cause;

  assign wait_go    = wait_valid && !waiting;
  assign wait_bad   = wait_go && wait_ext_bad(wait_ext, wait_timed);
  assign wait_imm   = wait_go && !wait_bad && (!armed || dirty || store_hit);
  assign wait_enter = wait_go && !wait_bad && !wait_imm;
  assign mon_go     = mon_valid && !waiting && !wait_valid;
  assign mon_bad    = mon_go && mon_ext_bad(mon_ext);
  assign arm_set    = mon_go && !mon_bad;
  assign irq_ok     = irq_pending && (irq_enabled || brk_q);
  assign wake_now   = waiting && wake_any;
  assign disarm     = wake_now || wait_imm;

  awu_line_watch #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_watch (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_addr(mon_addr),
    .disarm(disarm), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .armed(armed), .dirty(dirty), .hit(store_hit)
  );

  awu_countdown #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wait_enter),
    .load_en(wait_timed && wait_ext[1]), .load_val(wait_limit),
    .stop(wake_now), .expired(timer_expired)
  );

  awu_wake_arb u_arb (
    .store_hit(store_hit), .irq_ok(irq_ok), .tmo(timer_expired),
    .any(wake_any), .cause(arb_cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting    <= 1'b0;
      wake_pulse <= 1'b0;
      wake_cause <= 2'd0;
      fault      <= 1'b0;
      cstate     <= 4'd0;
      substate   <= 4'd0;
      brk_q      <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      fault      <= wait_bad || mon_bad;
      if (wake_now) begin
        waiting    <= 1'b0;
        wake_pulse <= 1'b1;
        wake_cause <= arb_cause;
        cstate     <= 4'd0;
        substate   <= 4'd0;
      end else if (wait_imm) begin
        wake_pulse <= 1'b1;
        wake_cause <= CAUSE_NOWAIT;
      end else if (wait_enter) begin
        waiting  <= 1'b1;
        brk_q    <= wait_ext[0];
        cstate   <= wait_hint[7:4];
        substate <= wait_hint[3:0];
      end
    end
  end

  assign deep_disabled = waiting && (cstate == CST_NO_DEEP);

  p_no_wait_and_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(waiting && wake_pulse));
  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !armed);
  p_store_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && store_hit |=> wake_pulse && wake_cause == 2'd0);
  p_irq_over_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !store_hit && irq_ok && timer_expired |=> wake_pulse && wake_cause == 2'd2);
  p_wait_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid && !waiting && ((|wait_ext[EXT_W-1:2]) || (!wait_timed && wait_ext[1]))
    |=> fault && !waiting && !wake_pulse);
  p_mon_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mon_valid && !waiting && !wait_valid && (mon_ext != '0) |=> fault && (armed == $past(armed)));
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !wake_any |=> waiting);
  p_cst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> !waiting || $stable(cstate));
  p_idle_cst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting |-> cstate == 4'd0 && substate == 4'd0 && !deep_disabled);
endmodule

// File: tb/tb_monitor_wait_unit.sv
`timescale 1ns/1ps
module tb_monitor_wait_unit;
  localparam int AW = 48;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_valid = 0, wait_valid = 0, wait_timed = 0;
  logic [AW-1:0] mon_addr = '0, snoop_addr = '0;
  logic [31:0]   mon_ext = '0, wait_ext = '0;
  logic [7:0]    wait_hint = '0;
  logic [CW-1:0] wait_limit = '0;
  logic          snoop_valid = 0, irq_pending = 0, irq_enabled = 0;
  logic          waiting, wake_pulse, fault, deep_disabled;
  logic [1:0]    wake_cause;
  logic [3:0]    cstate, substate;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  monitor_wait_unit dut (
    .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_ext(mon_ext),
    .wait_valid(wait_valid), .wait_timed(wait_timed), .wait_hint(wait_hint), .wait_ext(wait_ext),
    .wait_limit(wait_limit), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .irq_pending(irq_pending), .irq_enabled(irq_enabled), .waiting(waiting),
    .wake_pulse(wake_pulse), .wake_cause(wake_cause), .fault(fault), .cstate(cstate),
    .substate(substate), .deep_disabled(deep_disabled)
  );

  // behavioural reference model
  bit     m_armed, m_dirty, m_wait, m_ten, m_brk, m_wake, m_fault;
  longint m_line, m_cnt;
  int     m_cause, m_cst, m_sub;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_dirty = 0; m_wait = 0; m_ten = 0; m_brk = 0;
      m_wake = 0; m_fault = 0; m_line = 0; m_cnt = 0; m_cause = 0; m_cst = 0; m_sub = 0;
    end else begin
      bit hit, irq, tmo, bad;
      hit = snoop_valid && m_armed && ((longint'(snoop_addr) / 64) == m_line);
      irq = irq_pending && (irq_enabled || m_brk);
      tmo = m_ten && (m_cnt == 0);
      m_wake = 0; m_fault = 0;
      if (m_wait) begin
        if (hit || irq || tmo) begin
          m_wake = 1; m_cause = hit ? 0 : (irq ? 2 : 1);
          m_wait = 0; m_armed = 0; m_dirty = 0; m_ten = 0; m_cst = 0; m_sub = 0;
        end else if (m_ten && m_cnt > 0) m_cnt = m_cnt - 1;
      end else begin
        if (hit) m_dirty = 1;
        if (wait_valid) begin
          bad = (wait_ext[31:2] != 0) || (!wait_timed && wait_ext[1]);
          if (bad) m_fault = 1;
          else if (!m_armed || m_dirty) begin
            m_wake = 1; m_cause = 3; m_armed = 0; m_dirty = 0;
          end else begin
            m_wait = 1; m_ten = wait_timed && wait_ext[1]; m_cnt = longint'(wait_limit);
            m_brk = wait_ext[0]; m_cst = wait_hint / 16; m_sub = wait_hint % 16;
          end
        end else if (mon_valid) begin
          if (mon_ext != 0) m_fault = 1;
          else begin m_armed = 1; m_dirty = 0; m_line = longint'(mon_addr) / 64; end
        end
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 waiting vs model", waiting, m_wait);
      chk("R7 wake_pulse vs model", wake_pulse, m_wake);
      if (m_wake) chk("R7 wake_cause vs model", wake_cause, m_cause);
      chk("R2 fault vs model", fault, m_fault);
      chk("R9 cstate vs model", cstate, m_cst);
      chk("R9 substate vs model", substate, m_sub);
      chk("R9 deep_disabled vs model", deep_disabled, m_wait && m_cst == 15);
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic do_mon(longint a, logic [31:0] e);
    mon_valid = 1; mon_addr = a[AW-1:0]; mon_ext = e; step(); mon_valid = 0; mon_ext = 0;
  endtask
  task automatic do_wait(bit t, logic [7:0] h, logic [31:0] e, int lim);
    wait_valid = 1; wait_timed = t; wait_hint = h; wait_ext = e; wait_limit = lim;
    step(); wait_valid = 0; wait_ext = 0;
  endtask
  task automatic do_snoop(longint a);
    snoop_valid = 1; snoop_addr = a[AW-1:0]; step(); snoop_valid = 0;
  endtask

  localparam longint A = 64'h1000;
  localparam longint B = 64'h2000;

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R11 reset state
    chk("R11 waiting", waiting, 0); chk("R11 wake", wake_pulse, 0);
    chk("R11 fault", fault, 0); chk("R11 cstate", cstate, 0);
    // R3 nothing armed
    do_wait(0, 8'h21, 0, 0);
    chk("R3 no-arm wake", wake_pulse, 1); chk("R3 cause", wake_cause, 3); chk("R3 waiting", waiting, 0);
    // R1 bad monitor ext
    do_mon(A, 32'h5); chk("R1 fault", fault, 1);
    do_wait(0, 8'h21, 0, 0); chk("R1 not armed cause", wake_cause, 3);
    // R4 store hit inside line
    do_mon(A, 0); chk("R1 ok no fault", fault, 0);
    do_wait(0, 8'h21, 0, 0);
    chk("R1 armed -> waiting", waiting, 1); chk("R9 cstate", cstate, 2); chk("R9 substate", substate, 1);
    do_snoop(A + 64); chk("R4 other line ignored", waiting, 1);
    do_snoop(A + 37); chk("R4 wake", wake_pulse, 1); chk("R4 cause", wake_cause, 0); chk("R4 waiting", waiting, 0);
    step(); chk("R8 one-cycle pulse", wake_pulse, 0);
    do_wait(0, 8'h21, 0, 0); chk("R8 disarmed cause", wake_cause, 3);
    // R3 line written before wait
    do_mon(A, 0); do_snoop(A + 3);
    do_wait(0, 8'h00, 0, 0); chk("R3 dirty wake", wake_pulse, 1); chk("R3 dirty cause", wake_cause, 3);
    // R5 limit 0
    do_mon(A, 0); do_wait(1, 8'h10, 32'h2, 0); chk("R5 entered", waiting, 1);
    step(); chk("R5 L0 wake", wake_pulse, 1); chk("R5 L0 cause", wake_cause, 1);
    // R5 limit 5: waits 6 cycles
    do_mon(A, 0); do_wait(1, 8'h10, 32'h2, 5);
    for (int i = 0; i < 5; i++) begin step(); chk("R5 still waiting", waiting, 1); end
    step(); chk("R5 L5 wake", wake_pulse, 1); chk("R5 L5 cause", wake_cause, 1);
    // R5 timer not enabled, R6 masked irq
    do_mon(A, 0); do_wait(1, 8'h10, 32'h0, 0);
    step(); step(); chk("R5 no timer", waiting, 1);
    irq_pending = 1; irq_enabled = 0; step(); step(); chk("R6 masked ignored", waiting, 1);
    irq_enabled = 1; step(); chk("R6 irq wake", wake_pulse, 1); chk("R6 cause", wake_cause, 2);
    irq_pending = 0; irq_enabled = 0;
    // R6 break bit
    do_mon(A, 0); do_wait(0, 8'h10, 32'h1, 0); irq_pending = 1; step();
    chk("R6 break wake", wake_pulse, 1); chk("R6 break cause", wake_cause, 2); irq_pending = 0;
    // R7 store over irq
    do_mon(A, 0); do_wait(0, 8'h10, 32'h1, 0);
    irq_pending = 1; snoop_valid = 1; snoop_addr = A[AW-1:0]; step(); irq_pending = 0; snoop_valid = 0;
    chk("R7 store first", wake_cause, 0);
    // R7 irq over timer
    do_mon(A, 0); do_wait(1, 8'h10, 32'h3, 1); step(); chk("R7 pre", waiting, 1);
    irq_pending = 1; step(); irq_pending = 0;
    chk("R7 irq over timer", wake_cause, 2);
    // R2 faults keep arm
    do_mon(A, 0);
    do_wait(0, 8'h10, 32'h2, 0); chk("R2 untimed bit1", fault, 1); chk("R2 no wake", wake_pulse, 0);
    do_wait(1, 8'h10, 32'h20, 0); chk("R2 reserved", fault, 1); chk("R2 no wait", waiting, 0);
    do_wait(0, 8'h10, 32'h0, 0); chk("R2 arm kept", waiting, 1);
    // R10 commands during wait ignored
    do_mon(B, 0); do_wait(0, 8'h55, 0, 0); chk("R10 cstate kept", cstate, 1);
    do_snoop(B); chk("R10 new monitor ignored", waiting, 1);
    do_snoop(A); chk("R10 old line wakes", wake_cause, 0);
    do_wait(0, 8'h10, 0, 0); chk("R10 B never armed", wake_cause, 3);
    // R10 same-cycle monitor and wait
    mon_valid = 1; mon_addr = A[AW-1:0]; do_wait(0, 8'h10, 0, 0); mon_valid = 0;
    chk("R10 same cycle", wake_cause, 3);
    do_wait(0, 8'h10, 0, 0); chk("R10 monitor dropped", wake_cause, 3);
    // R9 deep disabled
    do_mon(A, 0); do_wait(0, 8'hF3, 0, 0); chk("R9 deep", deep_disabled, 1); chk("R9 cst F", cstate, 15);
    irq_pending = 1; irq_enabled = 1; step(); irq_pending = 0; irq_enabled = 0;
    chk("R9 cleared", cstate, 0); chk("R9 deep cleared", deep_disabled, 0);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      longint pool[4] = '{64'h1000, 64'h1020, 64'h1040, 64'h2000};
      mon_valid = ($urandom % 12) == 0; mon_addr = pool[$urandom % 4][AW-1:0];
      mon_ext = (($urandom % 8) == 0) ? 32'h4 : 32'h0;
      wait_valid = ($urandom % 6) == 0; wait_timed = $urandom % 2;
      wait_hint = 8'($urandom); wait_limit = $urandom % 8;
      wait_ext = (($urandom % 10) == 0) ? 32'h8 : {30'd0, 2'($urandom)};
      snoop_valid = ($urandom % 7) == 0; snoop_addr = (pool[$urandom % 4] + $urandom % 64);
      irq_pending = ($urandom % 25) == 0; irq_enabled = $urandom % 2;
      step();
    end
    mon_valid = 0; wait_valid = 0; snoop_valid = 0; irq_pending = 0;
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule